// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a load-multiple or store-multiple operation. When `start` is seen while the block is idle, it captures a register selection mask, a base value, the instruction address and five mode bits. These bits are pre/post increment, up/down, writeback, load/store and the privileged "S" bit. It then issues one word transfer per clock. Each transfer carries a register index, a word address, a sequential/non-sequential tag and a direction.

Descending operations are rewritten as ascending walks that start from a precomputed low address. Registers therefore always leave in rising index order, and the lowest index always sits at the lowest address. After the last transfer the block presents the written-back base value and a writeback enable, together with a flag saying that the program counter was loaded. Load sequences first spend one internal idle cycle.

For stores the block says when the value written must not come from the register file. This happens when the base register is stored, and when the program counter is stored. While busy, the block also indicates whether the register-file side must use the user-mode bank or must restore status from the saved copy. Memory, the register file and the bank switching itself live outside.

Top module: `blkx_seq`

## Requirements
- R1: Within one operation, transfers appear on consecutive cycles with `xfer_valid`=1, in strictly rising `xfer_idx` order, covering exactly the set bits of `reg_list`.
- R2: Each transfer address is 4 above the previous one. The first address depends on `up_bit` (1 = up) and `pre_bit` (1 = pre). For up it is base+4 when pre and base when post. For down it is base−4·n when pre and base−4·n+4 when post, where n is the number of set bits. Addresses wrap modulo 2^AW.
- R3: `xfer_seq` is 0 (non-sequential) on the first transfer of an operation and 1 on every later one.
- R4: In the done cycle, `wb_value` is base+4·n for up and base−4·n for down. `wb_en` equals `wb_bit`, except that it is 0 on a load (`load_bit`=1) whose list contains `base_idx`.
- R5: On a store whose list contains `base_idx`, that transfer has `sub_valid`=1. `sub_data` is the old base if `base_idx` is the lowest set bit, and the final base value of R4 otherwise.
- R6: On a store whose list contains index NREG−1 (the program counter, 15 by default) and that index is not `base_idx`, that transfer has `sub_valid`=1 with `sub_data` = `insn_addr`+12.
- R7: An empty list produces exactly one transfer, of index NREG−1, and the base moves by 4·NREG (0x40) up or down. A load uses the base as its address. A store uses base−0x3C for down/post, base−0x40 for down/pre, base for up/post and base+4 for up/pre, and its data is `insn_addr`+12.
- R8: While busy, `psr_restore`=1 exactly when `s_bit`, `load_bit` and list bit NREG−1 are all set. `user_bank`=1 exactly when `s_bit` is set and `psr_restore` is not.
- R9: On a load, the cycle after the last transfer has `idle_cycle`=1 and the next cycle has `done`=1. On a store, `done`=1 in the cycle right after the last transfer. `done` lasts one cycle, after which `busy` is 0.
- R10: `start` and all operation inputs are ignored while `busy`=1.
- R11: After reset, `busy`, `xfer_valid`, `idle_cycle`, `done` and `wb_en` are 0.
- R12: In the done cycle, `pc_loaded`=1 exactly for a load whose list contains index NREG−1 or is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| reg_list | input | NREG | Register selection mask |
| base_val | input | AW | Current base register value |
| base_idx | input | IDX_W | Index of the base register |
| insn_addr | input | AW | Address of the instruction being executed |
| pre_bit | input | 1 | 1 = adjust before access, 0 = after |
| up_bit | input | 1 | 1 = ascending, 0 = descending |
| wb_bit | input | 1 | Request base writeback |
| load_bit | input | 1 | 1 = load, 0 = store |
| s_bit | input | 1 | User-bank / status-restore request |
| busy | output | 1 | Operation in progress (includes done cycle) |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| xfer_idx | output | IDX_W | Register index of the transfer |
| xfer_addr | output | AW | Word address of the transfer |
| xfer_seq | output | 1 | 1 = sequential access, 0 = non-sequential |
| xfer_load | output | 1 | 1 = load transfer, 0 = store |
| sub_valid | output | 1 | Store data comes from `sub_data`, not the register file |
| sub_data | output | AW | Substitute store value |
| idle_cycle | output | 1 | Internal idle cycle at the end of a load |
| done | output | 1 | Final cycle; writeback outputs valid |
| wb_en | output | 1 | Write `wb_value` to the base register |
| wb_value | output | AW | Final base value |
| pc_loaded | output | 1 | Program counter was loaded (pipeline refill needed) |
| user_bank | output | 1 | Use the user-mode register bank for the transfers |
| psr_restore | output | 1 | Restore status from the saved copy |

## Verification
The bench builds the block with its defaults, NREG=16 and AW=32. With these values the program-counter index 15 and the full 16-register list are both reachable, and so are the empty-list offsets of 0x3C and 0x40. Small base values make descending addresses wrap through zero, which exercises the modulo arithmetic of R2. A behavioural model builds the expected transfer queue for each operation and compares it on every clock. One operation keeps `start` high and scrambles the inputs throughout, to show they are ignored while busy.

// File: rtl/blkx_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package blkx_pkg;

    // Controller phases: waiting, issuing transfers, load tail, final cycle.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2,
        ST_DONE = 2'd3
    } blkx_state_e;

endpackage

// File: rtl/blkx_plan.sv
// Operation planner: from the captured request it derives the list size,
// the first (lowest) transfer address, the final base value, the first
// mask to walk and the mode flags. Purely combinational.
// Assumes reg_list bit NREG-1 is the program counter.
module blkx_plan #(
    parameter int NREG  = 16,
    parameter int AW    = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  reg_list,
    input  logic [AW-1:0]    base_val,
    input  logic [IDX_W-1:0] base_idx,
    input  logic             pre_bit,
    input  logic             up_bit,
    input  logic             wb_bit,
    input  logic             load_bit,
    input  logic             s_bit,
    output logic             empty,
    output logic [NREG-1:0]  first_mask,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    final_base,
    output logic             wb_allow,
    output logic             pc_ld,
    output logic             psr_rst,
    output logic             usr_bank
);
    localparam int          CNT_W = $clog2(NREG + 1);
    localparam int          PC_IX = NREG - 1;
    localparam logic [AW-1:0] FULL_SPAN = AW'(4 * NREG);
    localparam logic [AW-1:0] WORD      = AW'(4);

    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    span;
    logic [AW-1:0]    low;

    // Count the selected registers.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt = cnt + CNT_W'(reg_list[i]);
        end
    end

    // Address plan: descending walks start from base minus the span.
    always_comb begin
        empty = (reg_list == '0);
        span  = empty ? FULL_SPAN : (AW'(cnt) << 2);
        low   = up_bit ? base_val : (base_val - span);
        if (empty) begin
            first_mask = NREG'(1) << PC_IX;
            if (load_bit) begin
                first_addr = base_val;
            end else if (up_bit) begin
                first_addr = pre_bit ? (base_val + WORD) : base_val;
            end else begin
                first_addr = pre_bit ? low : (low + WORD);
            end
        end else begin
            first_mask = reg_list;
            // Effective pre sense is inverted when walking a descending range.
            first_addr = (pre_bit == up_bit) ? (low + WORD) : low;
        end
        final_base = up_bit ? (base_val + span) : (base_val - span);
    end

    // Mode flags for writeback and register banking.
    always_comb begin
        wb_allow = wb_bit & ~(load_bit & ~empty & reg_list[base_idx]);
        pc_ld    = load_bit & (empty | reg_list[PC_IX]);
        psr_rst  = s_bit & load_bit & reg_list[PC_IX];
        usr_bank = s_bit & ~psr_rst;
    end

endmodule

// File: rtl/blkx_lowbit.sv
// Lowest-set-bit finder: gives the index of the lowest set bit of the
// mask and the mask with that bit cleared. Assumes W >= $clog2(N).
module blkx_lowbit #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] idx,
    output logic [N-1:0] rest
);
    logic [N-1:0] iso;

    // Isolate the lowest set bit and strip it from the remaining mask.
    always_comb begin
        iso  = mask & (~mask + N'(1));
        rest = mask & ~iso;
    end

    // One OR-reduction per index bit over the one-hot isolated bit.
    for (genvar b = 0; b < W; b++) begin : g_enc
        logic [N-1:0] sel;
        always_comb begin
            for (int i = 0; i < N; i++) begin
                sel[i] = iso[i] & (((i >> b) & 1) == 1);
            end
        end
        assign idx[b] = |sel;
    end

endmodule

// File: rtl/blkx_store_src.sv
// Store data source selector: decides when a stored value replaces the
// register file read (base register or program counter in the list).
// Assumes first_xfer marks the lowest listed register of a non-empty list.
module blkx_store_src #(
    parameter int NREG  = 16,
    parameter int AW    = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             active,
    input  logic             empty,
    input  logic             first_xfer,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [AW-1:0]    old_base,
    input  logic [AW-1:0]    final_base,
    input  logic [AW-1:0]    insn_addr,
    output logic             sub_valid,
    output logic [AW-1:0]    sub_data
);
    localparam logic [IDX_W-1:0] PC_IX  = IDX_W'(NREG - 1);
    localparam logic [AW-1:0]    PC_OFS = AW'(12);

    // Base register wins over the program-counter rule.
    always_comb begin
        sub_valid = 1'b0;
        sub_data  = '0;
        if (active) begin
            if (!empty && idx == base_idx) begin
                sub_valid = 1'b1;
                sub_data  = first_xfer ? old_base : final_base;
            end else if (idx == PC_IX) begin
                sub_valid = 1'b1;
                sub_data  = insn_addr + PC_OFS;
            end
        end
    end

endmodule

// File: rtl/blkx_seq.sv
// Block transfer address sequencer top. Captures a request when idle,
// issues one word transfer per cycle in rising register order, adds one
// idle cycle after loads, then presents writeback results for one cycle.
// Assumes the surrounding core holds off other memory traffic while busy.
module blkx_seq #(
    parameter int NREG  = 16,
    parameter int AW    = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NREG-1:0]  reg_list,
    input  logic [AW-1:0]    base_val,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [AW-1:0]    insn_addr,
    input  logic             pre_bit,
    input  logic             up_bit,
    input  logic             wb_bit,
    input  logic             load_bit,
    input  logic             s_bit,
    output logic             busy,
    output logic             xfer_valid,
    output logic [IDX_W-1:0] xfer_idx,
    output logic [AW-1:0]    xfer_addr,
    output logic             xfer_seq,
    output logic             xfer_load,
    output logic             sub_valid,
    output logic [AW-1:0]    sub_data,
    output logic             idle_cycle,
    output logic             done,
    output logic             wb_en,
    output logic [AW-1:0]    wb_value,
    output logic             pc_loaded,
    output logic             user_bank,
    output logic             psr_restore
);
    import blkx_pkg::*;

    localparam logic [AW-1:0] WORD = AW'(4);

    blkx_state_e      state_q;
    logic [NREG-1:0]  mask_q;
    logic [AW-1:0]    addr_q;
    logic             seq_q;
    logic             load_q;
    logic             empty_q;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    final_q;
    logic [AW-1:0]    insn_q;
    logic [IDX_W-1:0] bidx_q;
    logic             wb_allow_q;
    logic             pc_ld_q;
    logic             psr_q;
    logic             usr_q;

    logic             p_empty;
    logic [NREG-1:0]  p_mask;
    logic [AW-1:0]    p_addr;
    logic [AW-1:0]    p_final;
    logic             p_wb;
    logic             p_pc;
    logic             p_psr;
    logic             p_usr;
    logic [IDX_W-1:0] cur_idx;
    logic [NREG-1:0]  rest_mask;
    logic             store_act;

    blkx_plan #(.NREG(NREG), .AW(AW), .IDX_W(IDX_W)) u_plan (
        .reg_list   (reg_list),
        .base_val   (base_val),
        .base_idx   (base_idx),
        .pre_bit    (pre_bit),
        .up_bit     (up_bit),
        .wb_bit     (wb_bit),
        .load_bit   (load_bit),
        .s_bit      (s_bit),
        .empty      (p_empty),
        .first_mask (p_mask),
        .first_addr (p_addr),
        .final_base (p_final),
        .wb_allow   (p_wb),
        .pc_ld      (p_pc),
        .psr_rst    (p_psr),
        .usr_bank   (p_usr)
    );

    blkx_lowbit #(.N(NREG), .W(IDX_W)) u_lowbit (
        .mask (mask_q),
        .idx  (cur_idx),
        .rest (rest_mask)
    );

    // Request capture and the per-cycle walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mask_q     <= '0;
            addr_q     <= '0;
            seq_q      <= 1'b0;
            load_q     <= 1'b0;
            empty_q    <= 1'b0;
            base_q     <= '0;
            final_q    <= '0;
            insn_q     <= '0;
            bidx_q     <= '0;
            wb_allow_q <= 1'b0;
            pc_ld_q    <= 1'b0;
            psr_q      <= 1'b0;
            usr_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q    <= ST_XFER;
                        mask_q     <= p_mask;
                        addr_q     <= p_addr;
                        seq_q      <= 1'b0;
                        load_q     <= load_bit;
                        empty_q    <= p_empty;
                        base_q     <= base_val;
                        final_q    <= p_final;
                        insn_q     <= insn_addr;
                        bidx_q     <= base_idx;
                        wb_allow_q <= p_wb;
                        pc_ld_q    <= p_pc;
                        psr_q      <= p_psr;
                        usr_q      <= p_usr;
                    end
                end
                ST_XFER: begin
                    addr_q <= addr_q + WORD;
                    seq_q  <= 1'b1;
                    mask_q <= rest_mask;
                    if (rest_mask == '0) begin
                        state_q <= load_q ? ST_TAIL : ST_DONE;
                    end
                end
                ST_TAIL: state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Store data substitution for the base register and program counter.
    assign store_act = xfer_valid & ~load_q;

    blkx_store_src #(.NREG(NREG), .AW(AW), .IDX_W(IDX_W)) u_src (
        .active     (store_act),
        .empty      (empty_q),
        .first_xfer (~seq_q),
        .idx        (cur_idx),
        .base_idx   (bidx_q),
        .old_base   (base_q),
        .final_base (final_q),
        .insn_addr  (insn_q),
        .sub_valid  (sub_valid),
        .sub_data   (sub_data)
    );

    // Output decode from the controller registers.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        xfer_valid  = (state_q == ST_XFER);
        idle_cycle  = (state_q == ST_TAIL);
        done        = (state_q == ST_DONE);
        xfer_idx    = cur_idx;
        xfer_addr   = addr_q;
        xfer_seq    = xfer_valid & seq_q;
        xfer_load   = xfer_valid & load_q;
        wb_en       = done & wb_allow_q;
        wb_value    = final_q;
        pc_loaded   = done & pc_ld_q;
        user_bank   = busy & usr_q;
        psr_restore = busy & psr_q;
    end

    // Rising register order inside a burst.
    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_idx > $past(xfer_idx)));

    // Word step between consecutive transfers.
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> (xfer_addr == $past(xfer_addr) + WORD));

    // First access of a burst is non-sequential.
    p_first_ns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !$past(xfer_valid)) |-> !xfer_seq);

    // Later accesses are sequential.
    p_later_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid)) |-> xfer_seq);

    // Writeback only in the final cycle.
    p_wb_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // Idle cycle follows a load transfer and precedes done.
    p_tail_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cycle |-> $past(xfer_valid && xfer_load));

    p_tail_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cycle |=> done);

    // Done lasts one cycle and the block goes idle.
    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/test_blkx_seq.sv
`timescale 1ns/1ps
module test_blkx_seq;
    localparam int NREG = 16;
    localparam int AW   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_list = '0;
    logic [31:0] base_val = '0;
    logic [3:0]  base_idx = '0;
    logic [31:0] insn_addr = '0;
    logic        pre_bit = 1'b0, up_bit = 1'b0, wb_bit = 1'b0, load_bit = 1'b0, s_bit = 1'b0;
    logic        busy, xfer_valid, xfer_seq, xfer_load, sub_valid, idle_cycle, done;
    logic        wb_en, pc_loaded, user_bank, psr_restore;
    logic [3:0]  xfer_idx;
    logic [31:0] xfer_addr, sub_data, wb_value;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    blkx_seq #(.NREG(NREG), .AW(AW)) i_blkx_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list),
        .base_val(base_val), .base_idx(base_idx), .insn_addr(insn_addr),
        .pre_bit(pre_bit), .up_bit(up_bit), .wb_bit(wb_bit), .load_bit(load_bit),
        .s_bit(s_bit), .busy(busy), .xfer_valid(xfer_valid), .xfer_idx(xfer_idx),
        .xfer_addr(xfer_addr), .xfer_seq(xfer_seq), .xfer_load(xfer_load),
        .sub_valid(sub_valid), .sub_data(sub_data), .idle_cycle(idle_cycle),
        .done(done), .wb_en(wb_en), .wb_value(wb_value), .pc_loaded(pc_loaded),
        .user_bank(user_bank), .psr_restore(psr_restore)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One operation: behavioural model builds the expected queue, then
    // every cycle is compared at the falling edge.
    task automatic run_op(input logic [15:0] lst, input logic [31:0] base, input logic [3:0] bidx,
                          input logic [31:0] ia, input bit pre, input bit up, input bit wb,
                          input bit ld, input bit s, input bit poke, input string tag);
        int          n = $countones(lst);
        bit          emp = (lst == 16'h0);
        logic [31:0] span = emp ? 32'd64 : 32'(4 * n);
        logic [31:0] fin = up ? base + span : base - span;
        logic [31:0] a;
        int          q_idx[$];
        logic [31:0] q_sd[$];
        bit          q_sv[$];
        bit          e_psr = s && ld && lst[15];
        bit          e_usr = s && !e_psr;
        bit          e_wb = wb && !(ld && !emp && lst[bidx]);
        bit          e_pc = ld && (emp || lst[15]);
        if (emp) begin
            q_idx.push_back(15);
            if (ld) a = base;
            else if (up) a = pre ? base + 32'd4 : base;
            else a = pre ? base - 32'h40 : base - 32'h3C;
        end else begin
            for (int r = 0; r < 16; r++) if (lst[r]) q_idx.push_back(r);
            if (up) a = pre ? base + 32'd4 : base;
            else a = pre ? base - span : base - span + 32'd4;
        end
        for (int k = 0; k < q_idx.size(); k++) begin
            if (ld) begin
                q_sv.push_back(1'b0); q_sd.push_back(32'h0);
            end else if (!emp && q_idx[k] == int'(bidx)) begin
                q_sv.push_back(1'b1); q_sd.push_back(k == 0 ? base : fin);
            end else if (q_idx[k] == 15) begin
                q_sv.push_back(1'b1); q_sd.push_back(ia + 32'd12);
            end else begin
                q_sv.push_back(1'b0); q_sd.push_back(32'h0);
            end
        end
        @(negedge clk);
        reg_list = lst; base_val = base; base_idx = bidx; insn_addr = ia;
        pre_bit = pre; up_bit = up; wb_bit = wb; load_bit = ld; s_bit = s; start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < q_idx.size(); k++) begin
            // R1 R2 R3 R5 R6 R7: transfer fields
            chk({tag, " R1/R2/R3/R5/R6/R7 xfer"},
                {1'b1, 4'(xfer_valid), 4'(xfer_idx), xfer_addr, 4'(xfer_seq), 4'(xfer_load), 4'(sub_valid), sub_data},
                {1'b1, 4'd1, 4'(q_idx[k]), a + 32'(4 * k), 4'(k != 0), 4'(ld), 4'(q_sv[k]), q_sd[k]});
            // R8: banking flags while busy
            chk({tag, " R8 flags"}, {4'(busy), 4'(user_bank), 4'(psr_restore)}, {4'd1, 4'(e_usr), 4'(e_psr)});
            start = poke;
            if (poke) begin
                // R10: scramble inputs while busy
                reg_list = ~lst; base_val = base ^ 32'h5A5A_0000; base_idx = ~bidx;
                up_bit = ~up; load_bit = ~ld; wb_bit = ~wb;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        if (ld) begin
            // R9: load tail idle cycle
            chk({tag, " R9 tail"}, {4'(idle_cycle), 4'(xfer_valid), 4'(done)}, {4'd1, 4'd0, 4'd0});
            @(negedge clk);
        end
        // R4 R7 R9 R12: done cycle results
        chk({tag, " R4/R7/R9/R12 done"},
            {4'(done), 4'(xfer_valid), 4'(idle_cycle), 4'(wb_en), wb_value, 4'(pc_loaded)},
            {4'd1, 4'd0, 4'd0, 4'(e_wb), fin, 4'(e_pc)});
        @(negedge clk);
        // R9 R10: back to idle after a single done cycle
        chk({tag, " R9/R10 idle"}, {4'(busy), 4'(done), 4'(wb_en)}, {4'd0, 4'd0, 4'd0});
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset", {4'(busy), 4'(xfer_valid), 4'(idle_cycle), 4'(done), 4'(wb_en)}, '0);

        // R1 R2: up/post load with writeback
        run_op(16'h002A, 32'h0000_1000, 4'd0, 32'h100, 0, 1, 1, 1, 0, 0, "up_post_ld");
        // R5: up/pre store, base is the lowest listed register -> old base
        run_op(16'h000E, 32'h0000_2000, 4'd1, 32'h200, 1, 1, 1, 0, 0, 0, "base_first_st");
        // R5: down/pre store, base not lowest -> final base
        run_op(16'h00F0, 32'h0000_3000, 4'd6, 32'h300, 1, 0, 1, 0, 0, 0, "base_later_st");
        // R4: down/post load with base in list -> writeback suppressed
        run_op(16'h0318, 32'h0000_4000, 4'd4, 32'h400, 0, 0, 1, 1, 0, 0, "base_in_ld");
        // R6 R12: store with program counter, then load with program counter
        run_op(16'h8001, 32'h0000_5000, 4'd2, 32'h0000_0800, 1, 1, 0, 0, 0, 0, "pc_st");
        run_op(16'h8001, 32'h0000_5000, 4'd2, 32'h0000_0800, 0, 1, 1, 1, 0, 0, "pc_ld");
        // R7: empty list, all four store combinations and a load
        for (int c = 0; c < 4; c++) begin
            run_op(16'h0000, 32'h0000_6000, 4'd3, 32'h0000_0A00, c[0], c[1], 1, 0, 0, 0, "empty_st");
        end
        run_op(16'h0000, 32'h0000_7000, 4'd3, 32'h0000_0B00, 1, 0, 1, 1, 0, 0, "empty_ld");
        // R8: status restore and user bank
        run_op(16'hC000, 32'h0000_8000, 4'd0, 32'h0, 0, 1, 0, 1, 1, 0, "s_psr");
        run_op(16'h00C0, 32'h0000_8000, 4'd0, 32'h0, 0, 1, 0, 1, 1, 0, "s_usr_ld");
        run_op(16'h8003, 32'h0000_8000, 4'd5, 32'h40, 1, 0, 1, 0, 1, 0, "s_usr_st");
        // R2: descending full list wrapping through zero
        run_op(16'hFFFF, 32'h0000_0008, 4'd9, 32'h0, 1, 0, 1, 1, 0, 0, "wrap_full");
        // R10: inputs scrambled and start held high while busy
        run_op(16'h0505, 32'h0000_9000, 4'd0, 32'h0, 0, 1, 1, 0, 0, 1, "poke");
        run_op(16'h0160, 32'h0000_A000, 4'd7, 32'h0, 1, 0, 1, 1, 0, 1, "poke_ld");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule